// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block links a register bus to an external audio codec over a three-wire serial audio link. Software writes 32-bit stereo words into a transmit queue and reads captured words from a receive queue. Each word carries the left sample in its upper half and the right sample in its lower half. A clock generator derives the bit clock and the word-select clock from the block clock. The serializer and the deserializer move one stereo word per frame, most significant bit first, starting one bit clock after each word-select transition. Word select is low during the left channel.

Software sets a watermark for each queue. The interrupt line rises when the transmit queue has room above its watermark, or when the receive queue's free space drops below its watermark. Each of the two sources can be enabled on its own. Overrun and underrun conditions are kept in sticky flags that are cleared by writing 1. One control bit drives the codec reset pin directly, and another control bit empties both queues at once.

Top module: `stereo_serial_port`

## Requirements
- R1: After reset: control reads 0x00002200 (both watermarks 2), status reads 0x15, error reads 0, divide reads 0x080, and irq, codec_rst and bclk are low.
- R2: Registers sit at byte offsets 0x00 control, 0x04 status, 0x08 error, 0x0C divide, 0x10 transmit data and 0x14 receive data. The control fields are: bit 0 tx enable, bit 1 tx interrupt enable, bit 2 rx enable, bit 3 rx interrupt enable, [10:8] tx watermark, [14:12] rx watermark, bit 16 flush (reads 0), bit 17 codec reset. All other control bits read 0. Divide keeps only bits [9:0]. Transmit data reads 0.
- R3: Status bit 0 (tx alert) is 1 exactly when the transmit free slots (8 minus the words held) exceed the tx watermark.
- R4: Status bit 1 (rx alert) is 1 exactly when the receive free slots are fewer than the rx watermark.
- R5: Status bits 2, 3, 4 and 5 are tx empty, tx full, rx empty and rx full. Each queue holds 8 words.
- R6: irq equals (tx alert AND tx interrupt enable) OR (rx alert AND rx interrupt enable).
- R7: A transmit-data write while the transmit queue is full is dropped and sets error bit 0.
- R8: When tx is enabled and the queue is empty at the start of a frame, error bit 0 is set and the frame transmits zeros.
- R9: A completed receive word that arrives while the receive queue is full is dropped and sets error bit 1.
- R10: Error bits stay set until 1 is written to that bit. Writing 0 has no effect.
- R11: Framing: lrclk is low for the left channel. Each channel goes out MSB first, beginning one bclk after the lrclk edge, and changes on bclk falling edges. With sd_out looped back to sd_in, the received words equal the transmitted words in order.
- R12: The frame lasts 64*max(divide[9:6],1) clocks and contains 32 bclk periods. lrclk changes only at a bclk falling edge.
- R13: Writing 1 to control bit 16 empties both queues.
- R14: codec_rst follows control bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the master audio clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_en |
| sd_in | input | 1 | Serial data from the codec |
| sd_out | output | 1 | Serial data to the codec |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word-select clock, low for the left channel |
| irq | output | 1 | Watermark interrupt |
| codec_rst | output | 1 | Codec reset pin |

## Verification
The assertions check on every cycle that the queue occupancy stays within bounds, that a full queue stays full after a rejected write, that lrclk moves only at a bclk falling edge, that bclk stays idle while both directions are off, that an underrun frame starts with a zero bit, that error flags are sticky, that the codec pin follows control writes, and that irq stays low while both enables are clear. The bench scenarios show the arithmetic over whole configurations. It sweeps every watermark against every queue fill level and measures frame lengths for several divide values. It decodes the serial bits of a known word, and it checks that words return intact through a loopback, including the drop rules at a full queue.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned WM_W   = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_ERR  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 5'h14;

    typedef struct packed {
        logic            codec_rst;
        logic [WM_W-1:0] rx_wm;
        logic [WM_W-1:0] tx_wm;
        logic            rx_ie;
        logic            rx_en;
        logic            tx_ie;
        logic            tx_en;
    } ctrl_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (s_q.cnt == CNT_W'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign count   = s_q.cnt;
    assign rdata   = mem[s_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = (s_q.wp == PTR_W'(DEPTH-1)) ? '0 : s_q.wp + 1'b1;
            if (do_pop)  s_d.rp = (s_q.rp == PTR_W'(DEPTH-1)) ? '0 : s_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[s_q.wp] <= wdata;
    end

    // R5
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int DIV_W  = 10,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    output logic              bclk,
    output logic              lrclk,
    output logic [SLOT_W-1:0] slot,
    output logic              rise,
    output logic              fall
);
    localparam int HALF_W = DIV_W - SLOT_W - 1;

    typedef struct packed {
        logic [HALF_W-1:0] hc;
        logic              bclk;
        logic [SLOT_W-1:0] slot;
    } cg_st_t;

    cg_st_t s_d, s_q;
    logic [HALF_W-1:0] half;
    logic tick;
    logic unused_div;

    assign unused_div = ^div[SLOT_W:0];
    assign half  = (div[DIV_W-1:SLOT_W+1] == '0) ? HALF_W'(1) : div[DIV_W-1:SLOT_W+1];
    assign tick  = run && (s_q.hc == half - 1'b1);
    assign rise  = tick && !s_q.bclk;
    assign fall  = tick && s_q.bclk;
    assign bclk  = s_q.bclk;
    assign slot  = s_q.slot;
    assign lrclk = s_q.slot[SLOT_W-1];

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d = '0;
        end else if (tick) begin
            s_d.hc   = '0;
            s_d.bclk = !s_q.bclk;
            if (s_q.bclk) s_d.slot = s_q.slot + 1'b1;
        end else begin
            s_d.hc = s_q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R12
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (lrclk != $past(lrclk))) |-> $past(fall));
    // R12
    bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
    parameter int W      = 32,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tx_en,
    input  logic              fall,
    input  logic [SLOT_W-1:0] slot,
    input  logic              fifo_empty,
    input  logic [W-1:0]      fifo_data,
    output logic              pop,
    output logic              underrun,
    output logic              sd
);
    typedef struct packed {
        logic [W-1:0] sh;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic load;

    assign load     = fall && (slot == '0);
    assign pop      = load && tx_en && !fifo_empty;
    assign underrun = load && tx_en && fifo_empty;
    assign sd       = s_q.sh[W-1];

    always_comb begin
        s_d = s_q;
        if (!run)      s_d.sh = '0;
        else if (load) s_d.sh = pop ? fifo_data : '0;
        else if (fall) s_d.sh = {s_q.sh[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    zero_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !sd);
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
    parameter int W      = 32,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rx_en,
    input  logic              rise,
    input  logic [SLOT_W-1:0] slot,
    input  logic              sd,
    output logic              push,
    output logic [W-1:0]      word
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic         armed;
    } rx_st_t;

    rx_st_t s_d, s_q;
    logic active;
    logic unused_msb;

    assign active     = run && rx_en;
    assign push       = active && rise && s_q.armed && (slot == '0);
    assign word       = {s_q.sh[W-2:0], sd};
    assign unused_msb = s_q.sh[W-1];

    always_comb begin
        s_d = s_q;
        if (!active) begin
            s_d = '0;
        end else if (rise) begin
            s_d.sh = {s_q.sh[W-2:0], sd};
            if (slot == SLOT_W'(1)) s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              bclk,
    output logic              lrclk,
    output logic              irq,
    output logic              codec_rst
);
    localparam int W      = 32;
    localparam int SLOT_W = 5;
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(10'h080);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [1:0]       err;
        logic [DIV_W-1:0] div;
    } top_st_t;

    top_st_t s_d, s_q;

    logic wr, rd, flush, tx_push, rx_pop;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_free, rx_free;
    logic [W-1:0] tx_head, rx_head, rx_word;
    logic tx_pop, tx_under, rx_push, run, rise, fall;
    logic [SLOT_W-1:0] slot;
    logic tx_alert, rx_alert;
    logic [5:0] status;

    assign wr      = bus_en && bus_we;
    assign rd      = bus_en && !bus_we;
    assign flush   = wr && (bus_addr == OFF_CTRL) && bus_wdata[16];
    assign tx_push = wr && (bus_addr == OFF_TXD);
    assign rx_pop  = rd && (bus_addr == OFF_RXD);
    assign run     = s_q.ctrl.tx_en || s_q.ctrl.rx_en;

    ssp_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk, .rst_n, .flush, .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
        .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    ssp_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk, .rst_n, .flush, .push(rx_push), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    ssp_clkgen #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) i_clk (
        .clk, .rst_n, .run, .div(s_q.div), .bclk, .lrclk, .slot, .rise, .fall);

    ssp_tx #(.W(W), .SLOT_W(SLOT_W)) i_tx (
        .clk, .rst_n, .run, .tx_en(s_q.ctrl.tx_en), .fall, .slot,
        .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop),
        .underrun(tx_under), .sd(sd_out));

    ssp_rx #(.W(W), .SLOT_W(SLOT_W)) i_rx (
        .clk, .rst_n, .run, .rx_en(s_q.ctrl.rx_en), .rise, .slot, .sd(sd_in),
        .push(rx_push), .word(rx_word));

    assign tx_free  = CNT_W'(FIFO_DEPTH) - tx_cnt;
    assign rx_free  = CNT_W'(FIFO_DEPTH) - rx_cnt;
    assign tx_alert = tx_free > CNT_W'(s_q.ctrl.tx_wm);
    assign rx_alert = rx_free < CNT_W'(s_q.ctrl.rx_wm);
    assign status   = {rx_full, rx_empty, tx_full, tx_empty, rx_alert, tx_alert};
    assign irq      = (tx_alert && s_q.ctrl.tx_ie) || (rx_alert && s_q.ctrl.rx_ie);
    assign codec_rst = s_q.ctrl.codec_rst;

    always_comb begin
        s_d = s_q;
        if (wr && (bus_addr == OFF_CTRL)) begin
            s_d.ctrl.tx_en     = bus_wdata[0];
            s_d.ctrl.tx_ie     = bus_wdata[1];
            s_d.ctrl.rx_en     = bus_wdata[2];
            s_d.ctrl.rx_ie     = bus_wdata[3];
            s_d.ctrl.tx_wm     = bus_wdata[10:8];
            s_d.ctrl.rx_wm     = bus_wdata[14:12];
            s_d.ctrl.codec_rst = bus_wdata[17];
        end
        if (wr && (bus_addr == OFF_DIV)) s_d.div = bus_wdata[DIV_W-1:0];
        if (wr && (bus_addr == OFF_ERR)) s_d.err = s_q.err & ~bus_wdata[1:0];
        if ((tx_push && tx_full) || tx_under) s_d.err[0] = 1'b1;
        if (rx_push && rx_full)               s_d.err[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.ctrl.tx_wm <= WM_W'(2);
            s_q.ctrl.rx_wm <= WM_W'(2);
            s_q.div      <= DIV_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: bus_rdata = 32'({s_q.ctrl.codec_rst, 2'b00, s_q.ctrl.rx_wm, 1'b0,
                                       s_q.ctrl.tx_wm, 4'b0000, s_q.ctrl.rx_ie,
                                       s_q.ctrl.rx_en, s_q.ctrl.tx_ie, s_q.ctrl.tx_en});
            OFF_STAT: bus_rdata = 32'(status);
            OFF_ERR:  bus_rdata = 32'(s_q.err);
            OFF_DIV:  bus_rdata = 32'(s_q.div);
            OFF_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.err[0]) && !$past(wr && (bus_addr == OFF_ERR) && bus_wdata[0]))
        |-> s_q.err[0]);
    // R14
    codec_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr && (bus_addr == OFF_CTRL)) |-> (codec_rst == $past(bus_wdata[17])));
    // R6
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.tx_ie && !s_q.ctrl.rx_ie) |-> !irq);
endmodule

// File: tb/test_stereo_serial_port.sv
module test_stereo_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic sd_out, sd_in, bclk, lrclk, irq, codec_rst;
    int tests = 0, fails = 0;
    int nrise = 0;
    logic [31:0] rv;

    assign sd_in = sd_out;

    stereo_serial_port i_stereo_serial_port (
        .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .sd_in, .sd_out, .bclk, .lrclk, .irq, .codec_rst);

    always #2 clk = !clk;
    always @(posedge bclk) nrise++;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    function automatic logic [31:0] wv(input int i);
        return {16'h1000 + 16'(i) * 16'h0111, 16'hF000 - 16'(i) * 16'h0203};
    endfunction

    task automatic frame_len(input logic [31:0] d, input int exp_clk);
        longint t0, t1;
        int r0;
        wr(5'h00, 32'h2200);
        wr(5'h0C, d);
        wr(5'h00, 32'h2201);
        @(posedge lrclk); t0 = $time; r0 = nrise;
        @(posedge lrclk); t1 = $time;
        check("R12 frame clocks", 32'((t1 - t0) / 4), 32'(exp_clk));
        check("R12 bclk per frame", 32'(nrise - r0), 32'd32);
        wr(5'h00, 32'h2200);
    endtask

    initial begin
        logic [63:0] bits;
        logic lr1, lr17;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, rv); check("R1 ctrl", rv, 32'h2200);
        rd(5'h04, rv); check("R1 status", rv, 32'h15);
        rd(5'h08, rv); check("R1 error", rv, 32'h0);
        rd(5'h0C, rv); check("R1 divide", rv, 32'h80);
        check("R1 pins", {29'b0, irq, codec_rst, bclk}, 32'h0);

        // R2 field layout, R14 codec pin
        wr(5'h00, 32'h0003_7745);
        rd(5'h00, rv); check("R2 ctrl readback", rv, 32'h0002_7705);
        check("R14 codec pin high", 32'(codec_rst), 32'd1);
        wr(5'h00, 32'h2200);
        check("R14 codec pin low", 32'(codec_rst), 32'd0);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, rv); check("R2 divide width", rv, 32'h3FF);
        rd(5'h10, rv); check("R2 txdata reads zero", rv, 32'h0);
        wr(5'h08, 32'h3);

        // R12 frame length over several divide values
        frame_len(32'h080, 128);
        frame_len(32'h0C0, 192);
        frame_len(32'h020, 64);
        frame_len(32'h3C5, 960);
        wr(5'h0C, 32'h080);
        // R8 empty queue while enabled raised underrun
        rd(5'h08, rv); check("R8 underrun flag", rv, 32'h1);
        wr(5'h08, 32'h2);
        rd(5'h08, rv); check("R10 write 0 keeps flag", rv, 32'h1);
        wr(5'h08, 32'h1);
        rd(5'h08, rv); check("R10 write 1 clears", rv, 32'h0);

        // R3 R5 R6 tx watermark sweep
        for (int wm = 0; wm < 8; wm++) begin
            for (int k = 0; k <= 8; k++) begin
                logic al;
                wr(5'h00, 32'h1_2002 | (32'(wm) << 8));
                for (int j = 0; j < k; j++) wr(5'h10, wv(j));
                al = (8 - k) > wm;
                rd(5'h04, rv);
                check("R3 R5 tx status", rv,
                      {26'b0, 1'b0, 1'b1, (k == 8), (k == 0), 1'b0, al});
                check("R6 tx irq", 32'(irq), 32'(al));
            end
        end

        // R11 framing of one word, then R8 zero frame
        wr(5'h00, 32'h1_2200);
        wr(5'h08, 32'h3);
        wr(5'h10, 32'hA5C3_3C5A);
        wr(5'h00, 32'h2201);
        @(posedge bclk);
        lr1 = 1'b0; lr17 = 1'b0;
        for (int i = 1; i <= 64; i++) begin
            @(posedge bclk);
            bits[64 - i] = sd_out;
            if (i == 1)  lr1 = lrclk;
            if (i == 17) lr17 = lrclk;
        end
        wr(5'h00, 32'h2200);
        check("R11 left sample", 32'(bits[63:48]), 32'hA5C3);
        check("R11 right sample", 32'(bits[47:32]), 32'h3C5A);
        check("R11 lrclk low on left", 32'(lr1), 32'd0);
        check("R11 lrclk high on right", 32'(lr17), 32'd1);
        check("R8 zeros after underrun", bits[31:0], 32'h0);
        rd(5'h08, rv); check("R8 underrun after frame", rv, 32'h1);

        // R7 drop on full, R9 rx overrun, R11 loopback
        wr(5'h00, 32'h1_2200);
        wr(5'h08, 32'h3);
        for (int i = 0; i < 9; i++) wr(5'h10, wv(i));
        rd(5'h08, rv); check("R7 tx overrun flag", rv, 32'h1);
        rd(5'h04, rv); check("R7 tx full", rv, 32'h18);
        wr(5'h08, 32'h3);
        wr(5'h00, 32'h2205);
        repeat (13 * 128) @(negedge clk);
        wr(5'h00, 32'h2200);
        rd(5'h08, rv); check("R9 R8 both flags", rv, 32'h3);

        // R4 R5 R6 rx sweep while draining
        for (int k = 8; k >= 1; k--) begin
            for (int wm = 0; wm < 8; wm++) begin
                logic ra;
                wr(5'h00, (32'(wm) << 12) | 32'h0208);
                ra = (8 - k) < wm;
                rd(5'h04, rv);
                check("R4 R5 rx status", rv,
                      {26'b0, (k == 8), 1'b0, 1'b0, 1'b1, ra, 1'b1});
                check("R6 rx irq", 32'(irq), 32'(ra));
            end
            rd(5'h14, rv); check("R11 R7 loopback word", rv, wv(8 - k));
        end
        rd(5'h04, rv); check("R5 rx drained", rv, 32'h15);

        // R13 flush both queues
        wr(5'h00, 32'h2200);
        for (int i = 0; i < 3; i++) wr(5'h10, wv(i));
        wr(5'h00, 32'h2205);
        repeat (5 * 128) @(negedge clk);
        wr(5'h00, 32'h2200);
        wr(5'h10, wv(4));
        wr(5'h10, wv(5));
        rd(5'h04, rv); check("R13 both hold data", 32'(rv[4] | rv[2]), 32'h0);
        wr(5'h00, 32'h1_2200);
        rd(5'h04, rv); check("R13 flushed", rv, 32'h15);
        rd(5'h00, rv); check("R13 flush bit reads 0", rv, 32'h2200);

        summary();
    end
endmodule